// File: doc/BRIEF.md
# Pseudo-Noise Link Self-Test Generator and Checker

This block provides built-in self-test for one serial link channel. When self-test is switched on, a 23rd-order linear feedback generator produces a continuous pseudo-noise bit stream, packed into 10-bit code groups for the transmit path. The same recurrence drives a receive-side checker. The checker first fills its register from the incoming stream, so it locks to whatever phase the stream arrives in. After that it runs on its own predictions and counts every received code group that differs from them.

The bit sequence follows s[n] = s[n-5] XOR s[n-23], which is the polynomial 1 + x^5 + x^23. Bits go into a code group least significant first, so bit 0 is the oldest bit of the group. The mismatch count is 8 bits wide and saturates. Turning self-test on clears the count and the lock, and restarts both the generator and the checker.

Top module: `pn_bist`

## Requirements
- R1: On the edge that first samples `bist_en_i` high (the entry edge), the generator register is loaded with `SEED`, and `tx_valid_o` is low after that edge. Take the seed as history with s[22-k] = SEED[k]. Then s[n] = s[n-5] ^ s[n-23], and on the g-th edge after the entry edge `tx_data_o[j]` equals s[23+10g+j].
- R2: While `bist_en_i` stays high after the entry edge, `tx_valid_o` is high after every edge and the stream runs on without gaps.
- R3: The checker shifts each valid received group into its 23-bit register, least significant bit first. It raises `lock_o` after the third valid group following the entry edge. Only the last 23 of those 30 bits matter, and they may start at any bit phase of the sequence.
- R4: After lock, a valid received group that differs from the prediction in one or more bits adds exactly one to `err_cnt_o`, and a matching group adds nothing. The prediction advances by one group for each valid group, whether or not that group matched. Cycles with `rx_valid_i` low neither count nor advance the checker.
- R5: No group received before lock changes `err_cnt_o`.
- R6: `err_cnt_o` saturates at 0xFF and stays there while further mismatches arrive.
- R7: Every entry edge clears `err_cnt_o` to 0 and drops `lock_o`, even when a mismatching valid group arrives in the same cycle. It also restarts the generator from `SEED`.
- R8: While `bist_en_i` is low, `lock_o` and `tx_valid_o` are low, received groups are ignored, and `err_cnt_o` holds its value. After reset all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Code-group clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bist_en_i | input | 1 | Self-test enable |
| tx_data_o | output | 10 | Generated code group, bit 0 oldest |
| tx_valid_o | output | 1 | Generated code group valid |
| rx_data_i | input | 10 | Received code group, bit 0 oldest |
| rx_valid_i | input | 1 | Received code group valid |
| lock_o | output | 1 | Checker locked to received stream |
| err_cnt_o | output | 8 | Saturating mismatching-group count |

## Verification
The clear on entry and the counting of a mismatching group can land on the same edge. The bench provokes this by raising the enable in the very cycle it presents a fully inverted valid group to a checker whose count is saturated. It then requires a zero count and a dropped lock, so the clear must win. Saturation and an incoming mismatch also meet on every cycle of a long run of inverted groups. There the bench compares the count after each group with min(previous + 1, 255), computed on its own.

// File: rtl/pn_bist_pkg.sv
package pn_bist_pkg;
  localparam int PN_ORDER = 23;
  localparam int PN_TAP   = 5;
  localparam int CG_W     = 10;
  localparam int CNT_W    = 8;

  typedef enum logic [1:0] {
    CHK_IDLE,
    CHK_FILL,
    CHK_LOCK
  } chk_phase_e;
endpackage

// File: rtl/pn_step.sv
// Advances a PN history register by W bits; bits_o[0] is produced first.
module pn_step #(
  parameter int ORDER = 23,
  parameter int TAP   = 5,
  parameter int W     = 10
) (
  input  logic [ORDER-1:0] state_i,
  output logic [ORDER-1:0] state_o,
  output logic [W-1:0]     bits_o
);
  logic [ORDER-1:0] chain [W+1];

  assign chain[0] = state_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic nb;
    assign nb          = chain[i][TAP-1] ^ chain[i][ORDER-1];
    assign chain[i+1]  = {chain[i][ORDER-2:0], nb};
    assign bits_o[i]   = nb;
  end

  assign state_o = chain[W];
endmodule

// File: rtl/pn_gen.sv
module pn_gen #(
  parameter int               ORDER = 23,
  parameter int               TAP   = 5,
  parameter int               W     = 10,
  parameter logic [ORDER-1:0] SEED  = 23'h3A51C7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         run_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  logic [ORDER-1:0] st_q, st_nxt;
  logic [W-1:0]     bits;

  pn_step #(.ORDER(ORDER), .TAP(TAP), .W(W)) u_step (
    .state_i (st_q),
    .state_o (st_nxt),
    .bits_o  (bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SEED;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      st_q    <= SEED;
      valid_o <= 1'b0;
    end else if (run_i) begin
      st_q    <= st_nxt;
      data_o  <= bits;
      valid_o <= 1'b1;
    end else begin
      valid_o <= 1'b0;
    end
  end

  // R1: an all-zero register would lock the generator up
  a_r1_state_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (st_q != '0));

  // R2: valid only follows a running cycle
  a_r2_valid_from_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(run_i));
endmodule

// File: rtl/pn_chk.sv
module pn_chk
  import pn_bist_pkg::*;
#(
  parameter int ORDER = 23,
  parameter int TAP   = 5,
  parameter int W     = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] rx_data_i,
  input  logic         rx_valid_i,
  output logic         lock_o,
  output logic         mismatch_o
);
  localparam int FILL_GROUPS = (ORDER + W - 1) / W;
  localparam int FILL_W      = $clog2(FILL_GROUPS + 1);

  chk_phase_e       phase_q;
  logic [FILL_W-1:0] fill_q;
  logic [ORDER-1:0] st_q, pred_st, fill_st;
  logic [W-1:0]     pred_bits, rx_rev;

  pn_step #(.ORDER(ORDER), .TAP(TAP), .W(W)) u_step (
    .state_i (st_q),
    .state_o (pred_st),
    .bits_o  (pred_bits)
  );

  // first received bit ends up deepest in the register
  for (genvar j = 0; j < W; j++) begin : g_rev
    assign rx_rev[j] = rx_data_i[W-1-j];
  end
  assign fill_st = {st_q[ORDER-1-W:0], rx_rev};

  assign lock_o     = (phase_q == CHK_LOCK);
  assign mismatch_o = en_i && lock_o && rx_valid_i && (rx_data_i != pred_bits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= CHK_IDLE;
      fill_q  <= '0;
      st_q    <= '0;
    end else if (clr_i) begin
      phase_q <= CHK_FILL;
      fill_q  <= '0;
    end else if (!en_i) begin
      phase_q <= CHK_IDLE;
    end else if (rx_valid_i) begin
      unique case (phase_q)
        CHK_FILL: begin
          st_q   <= fill_st;
          fill_q <= fill_q + FILL_W'(1);
          if (fill_q == FILL_W'(FILL_GROUPS - 1)) phase_q <= CHK_LOCK;
        end
        CHK_LOCK: st_q <= pred_st;
        default:  phase_q <= CHK_IDLE;
      endcase
    end
  end

  // R3: lock only rises on a valid received group while enabled
  a_r3_lock_on_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($past(rx_valid_i) && $past(en_i)));

  // R8: no lock while disabled
  a_r8_no_lock_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !clr_i |=> !lock_o);
endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (clr_i)               cnt_o <= '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + CNT_W'(1);
  end

  // R6: sticky at full scale
  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX && !clr_i) |=> (cnt_o == MAX));

  // R4: moves by at most one per group
  a_r4_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + CNT_W'(1)));
endmodule

// File: rtl/pn_bist.sv
module pn_bist
  import pn_bist_pkg::*;
#(
  parameter int                  ORDER = PN_ORDER,
  parameter int                  TAP   = PN_TAP,
  parameter int                  W     = CG_W,
  parameter int                  CW    = CNT_W,
  parameter logic [ORDER-1:0]    SEED  = 23'h3A51C7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bist_en_i,
  output logic [W-1:0]  tx_data_o,
  output logic          tx_valid_o,
  input  logic [W-1:0]  rx_data_i,
  input  logic          rx_valid_i,
  output logic          lock_o,
  output logic [CW-1:0] err_cnt_o
);
  logic bist_q, entry, active, mismatch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bist_q <= 1'b0;
    else         bist_q <= bist_en_i;
  end

  assign entry  = bist_en_i && !bist_q;
  assign active = bist_en_i && bist_q;

  pn_gen #(.ORDER(ORDER), .TAP(TAP), .W(W), .SEED(SEED)) u_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (entry),
    .run_i   (active),
    .data_o  (tx_data_o),
    .valid_o (tx_valid_o)
  );

  pn_chk #(.ORDER(ORDER), .TAP(TAP), .W(W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (entry),
    .en_i       (active),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .lock_o     (lock_o),
    .mismatch_o (mismatch)
  );

  sat_cnt #(.CNT_W(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (entry),
    .inc_i  (mismatch),
    .cnt_o  (err_cnt_o)
  );

  // R7: entry wipes count, lock and transmit valid
  a_r7_clear_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bist_en_i && !bist_q) |=> (err_cnt_o == '0) && !lock_o && !tx_valid_o);

  // R5: unlocked checker never moves the count
  a_r5_hold_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bist_en_i && bist_q && !lock_o) |=> (err_cnt_o == $past(err_cnt_o)));

  // R8: disabled block holds count and drives no valid
  a_r8_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bist_en_i |=> (err_cnt_o == $past(err_cnt_o)) && !tx_valid_o);
endmodule

// File: tb/pn_bist_tb_top.sv
`timescale 1ns/1ps
module pn_bist_tb_top;
  localparam logic [22:0] SEED  = 23'h3A51C7;
  localparam int          SEQ_N = 8192;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bist_en_i = 1'b0;
  logic [9:0] tx_data_o;
  logic       tx_valid_o;
  logic [9:0] rx_data_i = '0;
  logic       rx_valid_i = 1'b0;
  logic       lock_o;
  logic [7:0] err_cnt_o;

  always #2 clk_i = ~clk_i;

  pn_bist #(.SEED(SEED)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bist_en_i  (bist_en_i),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .lock_o     (lock_o),
    .err_cnt_o  (err_cnt_o)
  );

  bit seq [SEQ_N];
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  int p = 0;
  int exp_cnt = 0;

  function automatic logic [9:0] grp(int at);
    logic [9:0] g;
    for (int j = 0; j < 10; j++) g[j] = seq[at+j];
    return g;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic send(bit v, logic [9:0] mask);
    rx_valid_i = v;
    rx_data_i  = v ? (grp(p) ^ mask) : 10'h155;
    cyc();
    if (v) p += 10;
  endtask

  initial begin
    for (int k = 0; k < 23; k++) seq[22-k] = SEED[k];
    for (int n = 23; n < SEQ_N; n++) seq[n] = seq[n-5] ^ seq[n-23];

    repeat (3) @(negedge clk_i);
    check(!tx_valid_o, "R8 reset tx_valid", tx_valid_o, 0);
    check(!lock_o, "R8 reset lock", lock_o, 0);
    check(err_cnt_o == 0, "R8 reset count", err_cnt_o, 0);
    rst_ni = 1'b1;
    cyc();

    // generator stream
    bist_en_i = 1'b1;
    cyc();
    check(!tx_valid_o, "R1 entry tx_valid", tx_valid_o, 0);
    for (int g = 0; g < 300; g++) begin
      cyc();
      check(tx_valid_o, "R2 tx_valid", tx_valid_o, 1);
      check(tx_data_o == grp(23 + 10*g), "R1 tx_data", tx_data_o, grp(23 + 10*g));
    end
    check(!lock_o, "R3 no lock without rx", lock_o, 0);

    // lock at an odd bit phase
    p = 7;
    send(1, 10'h0);
    check(!lock_o, "R3 lock after 1", lock_o, 0);
    send(1, 10'h0);
    check(!lock_o, "R3 lock after 2", lock_o, 0);
    send(1, 10'h0);
    check(lock_o, "R3 lock after 3", lock_o, 1);
    check(err_cnt_o == 0, "R5 count at lock", err_cnt_o, 0);

    for (int g = 0; g < 40; g++) begin
      send(1, 10'h0);
      check(err_cnt_o == 0, "R4 clean group", err_cnt_o, 0);
    end

    for (int g = 0; g < 10; g++) begin
      send(0, 10'h0);
      check(err_cnt_o == 0, "R4 invalid ignored", err_cnt_o, 0);
      send(1, 10'h0);
      check(err_cnt_o == 0, "R4 no advance on invalid", err_cnt_o, 0);
    end

    send(1, 10'h001);
    check(err_cnt_o == 1, "R4 single-bit error", err_cnt_o, 1);
    send(1, 10'h3C3);
    check(err_cnt_o == 2, "R4 multi-bit error", err_cnt_o, 2);
    send(1, 10'h0);
    check(err_cnt_o == 2, "R4 resync after error", err_cnt_o, 2);

    exp_cnt = 2;
    for (int k = 0; k < 260; k++) begin
      send(1, 10'h3FF);
      exp_cnt = (exp_cnt < 255) ? exp_cnt + 1 : 255;
      check(err_cnt_o == exp_cnt, "R6 saturating count", err_cnt_o, exp_cnt);
    end
    send(1, 10'h0);
    check(err_cnt_o == 255, "R6 hold clean", err_cnt_o, 255);

    // disabled
    bist_en_i = 1'b0;
    send(1, 10'h3FF);
    check(!lock_o, "R8 lock off", lock_o, 0);
    check(!tx_valid_o, "R8 tx_valid off", tx_valid_o, 0);
    check(err_cnt_o == 255, "R8 count held", err_cnt_o, 255);
    send(1, 10'h3FF);
    check(err_cnt_o == 255, "R8 rx ignored", err_cnt_o, 255);

    // re-entry coinciding with a mismatching group
    bist_en_i = 1'b1;
    send(1, 10'h3FF);
    check(err_cnt_o == 0, "R7 clear wins", err_cnt_o, 0);
    check(!lock_o, "R7 lock dropped", lock_o, 0);
    check(!tx_valid_o, "R7 entry tx_valid", tx_valid_o, 0);

    // early bits of the fill are corrupted; only the last 23 matter
    p = 1234;
    send(1, 10'h07F);
    check(tx_valid_o && tx_data_o == grp(23), "R7 generator restart", tx_data_o, grp(23));
    check(!lock_o, "R3 relock after 1", lock_o, 0);
    send(1, 10'h0);
    send(1, 10'h0);
    check(lock_o, "R3 relock after 3", lock_o, 1);
    check(err_cnt_o == 0, "R5 pre-lock errors", err_cnt_o, 0);
    for (int g = 0; g < 30; g++) begin
      send(1, 10'h0);
      check(err_cnt_o == 0, "R5 clean after relock", err_cnt_o, 0);
    end
    send(1, 10'h200);
    check(err_cnt_o == 1, "R4 count after relock", err_cnt_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule